// File: doc/BRIEF.md
# Timebase Timer with Edge Capture and Watchdog

This block is a small free-running timer for a microcontroller. A prescaler divides the oscillator-enabled system clock. The prescaled ticks drive an up-counter that restarts at the end of every timebase period. Each period end sets a timebase flag, and that flag can raise an interrupt. A synchronised rising edge on an external pin copies the upper bits of the counter into a capture register and sets a capture flag. The capture flag has its own interrupt line.

The same period ends also clock a watchdog. Software proves it is alive by setting a re-arm bit. Hardware clears that bit at the end of every watchdog period. If the watchdog is enabled and the bit is already clear when a period ends, the block emits a one-cycle reset request. When the oscillator is stopped, the prescaler and counter hold their values, so no timebase event and no reset request can occur until the oscillator runs again. Software reaches the block through a two-register bus: a control/status register and the capture data register. Reads of these registers have clear-on-read side effects.

Top module: `tbase_timer`

## Requirements
- R1: After reset the control/status register reads 0x00 and the capture register reads 0. The watchdog is disabled, the short period is selected, and `tb_irq`, `cap_irq` and `wdg_rst_req` are low.
- R2: The counter advances once every PRESCALE clocks in which `osc_run` is high. A timebase event occurs on the clock that completes PER_SHORT×PRESCALE running cycles when bit 2 is 0, or PER_LONG×PRESCALE running cycles when bit 2 is 1. The event sets the timebase flag (control bit 4) and restarts the counter at 0.
- R3: A read of address 0 clears the timebase flag. If a timebase event happens on the same clock as that read, the flag stays set.
- R4: `tb_irq` equals timebase flag AND control bit 3. `cap_irq` equals capture flag AND control bit 5. Each line is independent of the other flag.
- R5: A rising edge on `cap_in`, after a two-flop synchroniser, loads the upper CAP_W bits of the counter into the capture register (address 1, zero-extended) and sets the capture flag (control bit 6).
- R6: Writes do not change the capture flag. A read of address 1 clears it, unless a capture happens on the same clock.
- R7: Control bit 1 enables the watchdog. Writing 1 to bit 0 sets the re-arm bit, and writing 0 to it has no effect. Hardware clears the re-arm bit at every watchdog period end, which falls on every WDG_PERIODS-th timebase event.
- R8: At a watchdog period end with the watchdog enabled and the re-arm bit clear, `wdg_rst_req` pulses high for exactly one clock. If the re-arm bit is set at that point, no pulse is issued.
- R9: While `osc_run` is low the counter, the timebase flag and the watchdog hold still, and no reset request is issued. Counting resumes when `osc_run` returns high.
- R10: A write to address 0 stores bits 1, 2, 3 and 5. Bits 4 and 6 are read-only status, and bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_run | input | 1 | High while the oscillator runs; low freezes counting |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives clear-on-read) |
| bus_addr | input | 1 | 0 = control/status, 1 = capture data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| cap_in | input | 1 | Asynchronous capture pin |
| tb_irq | output | 1 | Timebase interrupt request |
| cap_irq | output | 1 | Capture interrupt request |
| wdg_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The bench builds the block with PRESCALE=4, CNT_W=6, CAP_W=3, PER_SHORT=10, PER_LONG=20 and WDG_PERIODS=2. With these values a timebase period lasts 40 or 80 clocks and a watchdog period lasts 80 clocks. Every period boundary, the coincidence of a read with a flag-setting event, and a missed re-arm can therefore be reached within a few hundred cycles. Holding `osc_run` low between bursts of a known length leaves the counter at a value the bench can compute. This gives a capture value the bench can predict, including a nonzero upper slice in the long-period mode.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  typedef enum logic {REG_CTRL = 1'b0, REG_CAP = 1'b1} tb_reg_e;

  localparam int unsigned B_KICK = 0;
  localparam int unsigned B_WDEN = 1;
  localparam int unsigned B_PSEL = 2;
  localparam int unsigned B_TBIE = 3;
  localparam int unsigned B_TBFL = 4;
  localparam int unsigned B_CPIE = 5;
  localparam int unsigned B_CPFL = 6;

  localparam logic [7:0] CTRL_WMASK = 8'h2E;
endpackage

// File: rtl/tbase_count.sv
module tbase_count #(
  parameter int unsigned PRESCALE  = 32,
  parameter int unsigned CNT_W     = 13,
  parameter int unsigned PER_SHORT = 250,
  parameter int unsigned PER_LONG  = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_run,
  input  logic             per_sel,
  output logic [CNT_W-1:0] cnt,
  output logic             tick,
  output logic             tb_evt
);
  localparam logic [CNT_W-1:0] LAST_S = CNT_W'(PER_SHORT - 1);
  localparam logic [CNT_W-1:0] LAST_L = CNT_W'(PER_LONG - 1);

  function automatic logic period_done(input logic [CNT_W-1:0] c, input logic sel);
    return c >= (sel ? LAST_L : LAST_S);
  endfunction

  generate
    if (PRESCALE > 1) begin : g_div
      localparam int unsigned PS_W = $clog2(PRESCALE);
      localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);
      logic [PS_W-1:0] presc;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       presc <= '0;
        else if (osc_run) presc <= (presc == PS_LAST) ? '0 : presc + 1'b1;
      end
      assign tick = osc_run && (presc == PS_LAST);

      AST_TB_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tb_evt |=> !tb_evt); // R2
    end else begin : g_nodiv
      assign tick = osc_run;
    end
  endgenerate

  assign tb_evt = tick && period_done(cnt, per_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (tick)  cnt <= tb_evt ? '0 : cnt + 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_L); // R2
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_run |=> $stable(cnt)); // R9
  AST_EVT_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    tb_evt |-> osc_run); // R9
endmodule

// File: rtl/tbase_capture.sv
module tbase_capture #(
  parameter int unsigned CAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_in,
  input  logic [CAP_W-1:0] cnt_hi,
  input  logic             rd_clr,
  output logic [CAP_W-1:0] cap_q,
  output logic             cap_flag,
  output logic             cap_evt
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
    end else begin
      s1 <= cap_in; s2 <= s1; s3 <= s2;
    end
  end

  assign cap_evt = s2 && !s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q    <= '0;
      cap_flag <= 1'b0;
    end else begin
      if (cap_evt)     cap_q <= cnt_hi;
      if (cap_evt)     cap_flag <= 1'b1;
      else if (rd_clr) cap_flag <= 1'b0;
    end
  end

  AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_flag && cap_q == $past(cnt_hi))); // R5
  AST_CAP_RDCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !cap_evt) |=> !cap_flag); // R6
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cap_q)); // R5
endmodule

// File: rtl/tbase_wdog.sv
module tbase_wdog #(
  parameter int unsigned WDG_PERIODS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tb_evt,
  input  logic en,
  input  logic kick_set,
  output logic kick,
  output logic wdg_end,
  output logic rst_req
);
  localparam int unsigned WC_W = (WDG_PERIODS > 1) ? $clog2(WDG_PERIODS) : 1;
  localparam logic [WC_W-1:0] WC_LAST = WC_W'(WDG_PERIODS - 1);

  logic [WC_W-1:0] wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wcnt <= '0;
    else if (tb_evt) wcnt <= (wcnt == WC_LAST) ? '0 : wcnt + 1'b1;
  end

  assign wdg_end = tb_evt && (wcnt == WC_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kick    <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (kick_set)     kick <= 1'b1;
      else if (wdg_end) kick <= 1'b0;
      rst_req <= wdg_end && en && !kick;
    end
  end

  AST_KICK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wdg_end && !kick_set) |=> !kick); // R7
  AST_KICK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdg_end && kick) |=> kick); // R7
  AST_WDG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R8
  AST_WDG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(en) && !$past(kick))); // R8
endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
  import tbase_pkg::*;
#(
  parameter int unsigned PRESCALE    = 32,
  parameter int unsigned CNT_W       = 13,
  parameter int unsigned CAP_W       = 8,
  parameter int unsigned PER_SHORT   = 250,
  parameter int unsigned PER_LONG    = 500,
  parameter int unsigned WDG_PERIODS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_run,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       cap_in,
  output logic       tb_irq,
  output logic       cap_irq,
  output logic       wdg_rst_req
);
  localparam int unsigned CAP_LSB = CNT_W - CAP_W;

  logic [CNT_W-1:0] cnt;
  logic             tick, tb_evt;
  logic [CAP_W-1:0] cap_q;
  logic             cap_flag, cap_evt;
  logic             kick, wdg_end;
  logic [7:0]       ctrl_q;
  logic             tb_flag;

  logic wr_ctrl, rd_ctrl, rd_cap, kick_set;
  assign wr_ctrl  = bus_wr && (bus_addr == REG_CTRL);
  assign rd_ctrl  = bus_rd && (bus_addr == REG_CTRL);
  assign rd_cap   = bus_rd && (bus_addr == REG_CAP);
  assign kick_set = wr_ctrl && bus_wdata[B_KICK];

  tbase_count #(
    .PRESCALE(PRESCALE), .CNT_W(CNT_W),
    .PER_SHORT(PER_SHORT), .PER_LONG(PER_LONG)
  ) u_count (
    .clk(clk), .rst_n(rst_n), .osc_run(osc_run),
    .per_sel(ctrl_q[B_PSEL]), .cnt(cnt), .tick(tick), .tb_evt(tb_evt)
  );

  tbase_capture #(.CAP_W(CAP_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in),
    .cnt_hi(cnt[CNT_W-1:CAP_LSB]), .rd_clr(rd_cap),
    .cap_q(cap_q), .cap_flag(cap_flag), .cap_evt(cap_evt)
  );

  tbase_wdog #(.WDG_PERIODS(WDG_PERIODS)) u_wdog (
    .clk(clk), .rst_n(rst_n), .tb_evt(tb_evt), .en(ctrl_q[B_WDEN]),
    .kick_set(kick_set), .kick(kick), .wdg_end(wdg_end), .rst_req(wdg_rst_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      tb_flag <= 1'b0;
    end else begin
      if (wr_ctrl)      ctrl_q <= bus_wdata & CTRL_WMASK;
      if (tb_evt)       tb_flag <= 1'b1;
      else if (rd_ctrl) tb_flag <= 1'b0;
    end
  end

  logic [7:0] status_bits;
  always_comb begin
    status_bits         = '0;
    status_bits[B_KICK] = kick;
    status_bits[B_TBFL] = tb_flag;
    status_bits[B_CPFL] = cap_flag;
  end

  always_comb begin
    if (bus_addr == REG_CTRL) bus_rdata = (ctrl_q & CTRL_WMASK) | status_bits;
    else                      bus_rdata = 8'(cap_q);
  end

  assign tb_irq  = tb_flag  && ctrl_q[B_TBIE];
  assign cap_irq = cap_flag && ctrl_q[B_CPIE];

  AST_TB_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tb_evt |=> tb_flag); // R3
  AST_TB_RDCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && !tb_evt) |=> !tb_flag); // R3
  AST_RO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !rd_ctrl && !tb_evt) |=> $stable(tb_flag)); // R10
  AST_RST_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdg_rst_req) |-> $past(osc_run)); // R9
  AST_WDG_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_rst_req |-> $past(wdg_end)); // R8
  AST_CTRL_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr |-> !bus_rdata[7]); // R10
endmodule

// File: tb/tbase_timer_tb_top.sv
module tbase_timer_tb_top;
  localparam int PS = 4, CW = 6, KW = 3, PSH = 10, PLG = 20, WP = 2;

  logic clk = 1'b0, rst_n = 1'b0, osc_run = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0, cap_in = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic tb_irq, cap_irq, wdg_rst_req;

  int n_chk = 0, n_bad = 0, pulses = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tbase_timer #(.PRESCALE(PS), .CNT_W(CW), .CAP_W(KW), .PER_SHORT(PSH),
                .PER_LONG(PLG), .WDG_PERIODS(WP)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_run(osc_run), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cap_in(cap_in), .tb_irq(tb_irq),
    .cap_irq(cap_irq), .wdg_rst_req(wdg_rst_req));

  always @(negedge clk) if (wdg_rst_req) pulses++;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; osc_run = 1'b0; cap_in = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    pulses = 0;
  endtask

  task automatic run_osc(input int n);
    osc_run = 1'b1;
    repeat (n) @(negedge clk);
    osc_run = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    bus_rd = 1'b1; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_cap();
    cap_in = 1'b1;
    repeat (5) @(negedge clk);
    cap_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    rd(1'b0, v); chk("R1 ctrl", v, 8'h00);
    rd(1'b1, v); chk("R1 cap", v, 8'h00);
    chk("R1 irqs/req", {5'b0, tb_irq, cap_irq, wdg_rst_req}, 8'h00);
  endtask

  task automatic t_timebase();
    logic [7:0] v;
    do_reset();
    run_osc(PSH*PS - 1);
    rd(1'b0, v); chk("R2 short before end", v, 8'h00);
    run_osc(1);
    rd(1'b0, v); chk("R2 short at end", v, 8'h10);
    rd(1'b0, v); chk("R3 cleared by read", v, 8'h00);
    do_reset();
    wr(1'b0, 8'h04);
    run_osc(PLG*PS - 1);
    rd(1'b0, v); chk("R2 long before end", v, 8'h04);
    run_osc(1);
    rd(1'b0, v); chk("R2 long at end", v, 8'h14);
  endtask

  task automatic t_coincide();
    logic [7:0] v;
    do_reset();
    run_osc(PSH*PS - 1);
    osc_run = 1'b1;
    rd(1'b0, v);
    osc_run = 1'b0;
    chk("R3 read before event", v, 8'h00);
    rd(1'b0, v); chk("R3 set wins over read", v, 8'h10);
    rd(1'b0, v); chk("R3 later read clears", v, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    do_reset();
    wr(1'b0, 8'h08);
    run_osc(PSH*PS);
    chk("R4 tb irq on", {6'b0, tb_irq, cap_irq}, 8'h02);
    pulse_cap();
    chk("R4 cap masked", {6'b0, tb_irq, cap_irq}, 8'h02);
    wr(1'b0, 8'h28);
    chk("R4 both on", {6'b0, tb_irq, cap_irq}, 8'h03);
    rd(1'b0, v);
    chk("R4 tb cleared only", {6'b0, tb_irq, cap_irq}, 8'h01);
    rd(1'b1, v);
    chk("R4 cap cleared", {6'b0, tb_irq, cap_irq}, 8'h00);
  endtask

  task automatic t_capture();
    logic [7:0] v;
    do_reset();
    wr(1'b0, 8'h04);
    run_osc(17*PS + 2);          // counter 17 -> upper slice 2
    pulse_cap();
    rd(1'b0, v); chk("R5 flag set", v, 8'h44);
    rd(1'b1, v); chk("R5 long-mode value", v, 8'h02);
    rd(1'b0, v); chk("R6 read of data clears flag", v, 8'h04);
    do_reset();
    run_osc(9*PS);               // counter 9 -> upper slice 1
    pulse_cap();
    rd(1'b1, v); chk("R5 short-mode value", v, 8'h01);
  endtask

  task automatic t_cap_ro();
    logic [7:0] v;
    do_reset();
    wr(1'b0, 8'h40);
    rd(1'b0, v); chk("R6 write 1 ignored", v, 8'h00);
    pulse_cap();
    wr(1'b0, 8'h00);
    rd(1'b0, v); chk("R6 write 0 ignored", v, 8'h40);
    rd(1'b1, v);
    cap_in = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(1'b1, v);                 // read on the capture clock
    cap_in = 1'b0;
    rd(1'b0, v); chk("R6 capture wins over read", v, 8'h40);
  endtask

  task automatic t_ctrl_bits();
    logic [7:0] v;
    do_reset();
    wr(1'b0, 8'hFF);
    rd(1'b0, v); chk("R10 writable bits", v, 8'h2F);
    wr(1'b0, 8'h00);
    rd(1'b0, v); chk("R7 kick survives write 0", v, 8'h01);
  endtask

  task automatic t_wdog();
    logic [7:0] v;
    do_reset();
    wr(1'b0, 8'h03);
    run_osc(WP*PSH*PS);
    chk("R8 no pulse when re-armed", 8'(pulses), 8'd0);
    rd(1'b0, v); chk("R7 kick cleared at period end", v, 8'h12);
    run_osc(WP*PSH*PS);
    repeat (4) @(negedge clk);
    chk("R8 one pulse on miss", 8'(pulses), 8'd1);
    wr(1'b0, 8'h03);
    run_osc(WP*PSH*PS);
    repeat (4) @(negedge clk);
    chk("R8 re-arm prevents pulse", 8'(pulses), 8'd1);
  endtask

  task automatic t_halt();
    logic [7:0] v;
    do_reset();
    wr(1'b0, 8'h02);
    repeat (300) @(negedge clk);
    chk("R9 no pulse while halted", 8'(pulses), 8'd0);
    rd(1'b0, v); chk("R9 no tb event while halted", v, 8'h02);
    run_osc(WP*PSH*PS);
    repeat (4) @(negedge clk);
    chk("R9 pulse after wakeup", 8'(pulses), 8'd1);
  endtask

  initial begin
    t_reset();
    t_timebase();
    t_coincide();
    t_irq();
    t_capture();
    t_cap_ro();
    t_ctrl_bits();
    t_wdog();
    t_halt();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R2 timeout actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule